// File: doc/BRIEF.md
# Receive Byte Buffer with Timed Redelivery

This block sits between a serial receiver (or a loopback source) and the host-visible receive data register. Incoming bytes go into a circular store of 2^ADDR_W entries (256 by default). The block owns the data-ready flag and the receive interrupt request, and both follow the same rule.

Every host read drops data-ready at once. When bytes are still waiting, the flag comes back only after a programmable number of clock cycles. This paces a host that drains the buffer from its interrupt handler. A host read of an empty buffer hands back the byte delivered last time and leaves the pointers alone. A push into a full buffer loses the byte and sets a sticky overflow flag. A clear input empties the store, drops every flag and stops the redelivery countdown.

Top module: `rx_redeliver_buf`

## Requirements
- R1: After reset, dataReady, rxIrq and overflow are 0 and readData is 0x00.
- R2: An accepted push while dataReady is 0 (and no read or clear in the same cycle) makes dataReady and rxIrq 1 from the next clock edge.
- R3: Bytes come out in the order they were pushed. readData shows the delivered byte from the clock edge that samples readStrobe onward, and holds it until the next read.
- R4: A sampled readStrobe makes dataReady and rxIrq 0 from the next clock edge, whatever else happens in that cycle.
- R5: If bytes remain after a read, dataReady returns exactly DELAY_CYC clock edges after the edge that sampled the read, and not earlier. No push is needed. If none remain, it stays 0.
- R6: A further read before the delay has run out restarts the full DELAY_CYC countdown.
- R7: A read of an empty buffer returns the previously delivered byte, and the next pushed byte is the next one delivered.
- R8: A push that lands while dataReady is 0 during a pending delay raises dataReady at the next edge, without waiting for the countdown.
- R9: The buffer holds 2^ADDR_W bytes. A push into a full buffer is dropped and sets overflow, which stays 1 until clear or reset. Pointers wrap, so order is kept across the wrap.
- R10: clearBuf empties the buffer, makes dataReady, rxIrq and overflow 0 at the next edge, and cancels a pending redelivery. A later empty read still returns the last delivered byte.
- R11: rxIrq equals dataReady in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pushValid | input | 1 | Store pushData this cycle |
| pushData | input | DATA_W | Byte from the receiver or loopback path |
| readStrobe | input | 1 | Host read of the receive data register |
| readData | output | DATA_W | Byte delivered by the most recent read |
| dataReady | output | 1 | Receive data available flag |
| rxIrq | output | 1 | Receive interrupt request |
| clearBuf | input | 1 | Flush the buffer and drop all flags |
| overflow | output | 1 | Sticky: a byte was dropped because the buffer was full |

## Verification
Each result is registered once. readData and the cleared dataReady are therefore valid one edge after the read is sampled, and a push raises dataReady one edge after it is sampled. The bench drives inputs on the falling edge and samples 5 ns after the rising edge that consumes them. Redelivery comes DELAY_CYC edges after the sampling edge of the read. The bench checks the flag one cycle before that point (still 0) and at that point (1). The restart test reads again part-way through the delay and then checks, past the point where the first countdown would have ended, that the flag is still 0.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
  // Strobes handed from control to datapath, one per cycle
  typedef struct packed {
    logic pushEn;    // write pushData and advance write pointer
    logic popEn;     // load readData from the head and advance read pointer
    logic clearAll;  // zero both pointers and the occupancy
  } bufStrobe_t;
endpackage

// File: rtl/rxbuf_datapath.sv
module rxbuf_datapath
  import rxbuf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bufStrobe_t        strobe,
  input  logic [DATA_W-1:0] pushData,
  output logic [DATA_W-1:0] readData,
  output logic [ADDR_W:0]   level,
  output logic              bufEmpty,
  output logic              bufFull
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W:0] FULL_LVL = (ADDR_W+1)'(DEPTH);

  logic [DATA_W-1:0] store [DEPTH];
  logic [ADDR_W-1:0] wrPtr, rdPtr;
  logic [ADDR_W:0]   levelNext;

  assign bufEmpty = (level == '0);
  assign bufFull  = (level == FULL_LVL);

  // Storage carries no reset; only written entries are ever read
  always_ff @(posedge clk) begin
    if (strobe.pushEn) store[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (strobe.clearAll) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.pushEn) wrPtr <= wrPtr + 1'b1;
      if (strobe.popEn)  rdPtr <= rdPtr + 1'b1;
    end
  end

  always_comb begin
    levelNext = level;
    if (strobe.clearAll) levelNext = '0;
    else begin
      if (strobe.pushEn) levelNext = levelNext + 1'b1;
      if (strobe.popEn)  levelNext = levelNext - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level <= '0;
    else        level <= levelNext;
  end

  // Delivered byte is held until the next successful pop
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            readData <= '0;
    else if (strobe.popEn) readData <= store[rdPtr];
  end
endmodule

// File: rtl/rxbuf_control.sv
module rxbuf_control
  import rxbuf_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DELAY_CYC = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pushValid,
  input  logic            readStrobe,
  input  logic            clearBuf,
  input  logic            bufEmpty,
  input  logic            bufFull,
  input  logic [ADDR_W:0] level,
  output bufStrobe_t      strobe,
  output logic            dataReady,
  output logic            rxIrq,
  output logic            overflow
);
  localparam int TMR_W = $clog2(DELAY_CYC + 1);
  localparam logic [TMR_W-1:0] RELOAD = TMR_W'(DELAY_CYC);
  localparam logic [TMR_W-1:0] LAST   = TMR_W'(1);

  generate
    if (DELAY_CYC < 1) begin : g_badDelay
      $error("DELAY_CYC must be at least 1");
    end
  endgenerate

  logic [TMR_W-1:0] delayCnt, delayNext;
  logic [ADDR_W:0]  remainAfter;
  logic             hostRead, timerExpire, readyNext, ovfNext;

  always_comb begin
    strobe.clearAll = clearBuf;
    strobe.pushEn   = pushValid  && !bufFull  && !clearBuf;
    strobe.popEn    = readStrobe && !bufEmpty && !clearBuf;
  end

  assign hostRead    = readStrobe && !clearBuf;
  assign timerExpire = (delayCnt == LAST);

  // Occupancy once this cycle's pop and push have taken effect
  always_comb begin
    remainAfter = level;
    if (strobe.pushEn) remainAfter = remainAfter + 1'b1;
    if (strobe.popEn)  remainAfter = remainAfter - 1'b1;
  end

  // Redelivery countdown: loaded by a read that leaves data behind
  always_comb begin
    delayNext = delayCnt;
    if (clearBuf)                         delayNext = '0;
    else if (hostRead && remainAfter != '0) delayNext = RELOAD;
    else if (hostRead)                    delayNext = '0;
    else if (delayCnt != '0)              delayNext = delayCnt - 1'b1;
  end

  // Ready priority: clear, then read, then push-on-idle, then expiry
  always_comb begin
    readyNext = dataReady;
    if (clearBuf)                         readyNext = 1'b0;
    else if (readStrobe)                  readyNext = 1'b0;
    else if (strobe.pushEn && !dataReady) readyNext = 1'b1;
    else if (timerExpire && !bufEmpty)    readyNext = 1'b1;
  end

  always_comb begin
    ovfNext = overflow;
    if (clearBuf)                  ovfNext = 1'b0;
    else if (pushValid && bufFull) ovfNext = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      delayCnt  <= '0;
      dataReady <= 1'b0;
      rxIrq     <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      delayCnt  <= delayNext;
      dataReady <= readyNext;
      rxIrq     <= readyNext;
      overflow  <= ovfNext;
    end
  end
endmodule

// File: rtl/rx_redeliver_buf.sv
module rx_redeliver_buf
  import rxbuf_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 8,
  parameter int DELAY_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pushValid,
  input  logic [DATA_W-1:0] pushData,
  input  logic              readStrobe,
  output logic [DATA_W-1:0] readData,
  output logic              dataReady,
  output logic              rxIrq,
  input  logic              clearBuf,
  output logic              overflow
);
  bufStrobe_t      strobe;
  logic [ADDR_W:0] level;
  logic            bufEmpty, bufFull;

  rxbuf_control #(.ADDR_W(ADDR_W), .DELAY_CYC(DELAY_CYC)) ctl (
    .clk(clk), .rst_n(rst_n), .pushValid(pushValid), .readStrobe(readStrobe),
    .clearBuf(clearBuf), .bufEmpty(bufEmpty), .bufFull(bufFull), .level(level),
    .strobe(strobe), .dataReady(dataReady), .rxIrq(rxIrq), .overflow(overflow)
  );

  rxbuf_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .pushData(pushData),
    .readData(readData), .level(level), .bufEmpty(bufEmpty), .bufFull(bufFull)
  );
endmodule

// File: rtl/rxbuf_checker.sv
module rxbuf_checker #(
  parameter int DATA_W    = 8,
  parameter int DELAY_CYC = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pushValid,
  input logic              readStrobe,
  input logic              clearBuf,
  input logic [DATA_W-1:0] readData,
  input logic              dataReady,
  input logic              rxIrq,
  input logic              overflow,
  input logic              bufEmpty,
  input logic              bufFull
);
  localparam int CW = $clog2(DELAY_CYC + 2);
  localparam logic [CW-1:0] SAT = CW'(DELAY_CYC + 1);

  // Edges since the last sampled read, saturating one past the delay
  logic [CW-1:0] sinceRead;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       sinceRead <= SAT;
    else if (readStrobe && !clearBuf) sinceRead <= CW'(1);
    else if (sinceRead != SAT)        sinceRead <= sinceRead + 1'b1;
  end

  // R2
  push_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pushValid && !bufFull && !dataReady && !readStrobe && !clearBuf) |=> dataReady);

  // R4
  read_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    readStrobe |=> (!dataReady && !rxIrq));

  // R5
  no_early_redeliver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dataReady) |-> ($past(pushValid) || sinceRead == SAT));

  // R7
  empty_read_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (readStrobe && bufEmpty && !clearBuf) |=> $stable(readData));

  // R9
  full_push_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pushValid && bufFull && !clearBuf) |=> overflow);

  // R9
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clearBuf) |=> overflow);

  // R10
  clear_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clearBuf |=> (!dataReady && !overflow && bufEmpty));

  // R11
  irq_tracks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxIrq == dataReady);
endmodule

bind rx_redeliver_buf rxbuf_checker #(.DATA_W(DATA_W), .DELAY_CYC(DELAY_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .pushValid(pushValid), .readStrobe(readStrobe),
  .clearBuf(clearBuf), .readData(readData), .dataReady(dataReady), .rxIrq(rxIrq),
  .overflow(overflow), .bufEmpty(bufEmpty), .bufFull(bufFull)
);

// File: tb/rx_redeliver_buf_test.sv
module rx_redeliver_buf_test;
  localparam int DW = 8, AW = 8, DLY = 12, DEPTH = 256;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          pushValid = 1'b0, readStrobe = 1'b0, clearBuf = 1'b0;
  logic [DW-1:0] pushData = '0;
  logic [DW-1:0] readData;
  logic          dataReady, rxIrq, overflow;

  rx_redeliver_buf #(.DATA_W(DW), .ADDR_W(AW), .DELAY_CYC(DLY)) uut (
    .clk(clk), .rst_n(rst_n), .pushValid(pushValid), .pushData(pushData),
    .readStrobe(readStrobe), .readData(readData), .dataReady(dataReady),
    .rxIrq(rxIrq), .clearBuf(clearBuf), .overflow(overflow)
  );

  int nChk = 0, nErr = 0;
  logic [DW-1:0] modelQ[$];
  logic [DW-1:0] expQ[$];
  logic [DW-1:0] lastByte = '0;
  logic wasRead;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pushByte(input logic [DW-1:0] d);
    @(negedge clk);
    pushValid = 1'b1;
    pushData  = d;
    if (modelQ.size() < DEPTH) modelQ.push_back(d);
    @(negedge clk);
    pushValid = 1'b0;
  endtask

  task automatic readByte();
    @(negedge clk);
    readStrobe = 1'b1;
    if (modelQ.size() > 0) lastByte = modelQ.pop_front();
    expQ.push_back(lastByte);
    @(negedge clk);
    readStrobe = 1'b0;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compares each delivered byte against the scoreboard (R3, R7)
  initial begin
    forever begin
      @(posedge clk);
      wasRead = readStrobe && !clearBuf && rst_n;
      #5;
      if (wasRead) begin
        if (expQ.size() == 0) chk("R3 unexpected read", 32'd1, 32'd0);
        else chk("R3/R7 delivered byte", 32'(readData), 32'(expQ.pop_front()));
      end
      if (rst_n) begin
        nChk++;
        if (rxIrq !== dataReady) begin
          nErr++;
          $display("FAIL R11 rxIrq actual=%0b expected=%0b", rxIrq, dataReady);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nErr++;
    nChk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

  initial begin
    waitCyc(3);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 dataReady", 32'(dataReady), 0);
    chk("R1 rxIrq", 32'(rxIrq), 0);
    chk("R1 overflow", 32'(overflow), 0);
    chk("R1 readData", 32'(readData), 0);

    // R2 first push raises the flag next edge
    pushByte(8'hA1);
    chk("R2 dataReady", 32'(dataReady), 1);
    chk("R2 rxIrq", 32'(rxIrq), 1);
    pushByte(8'hB2);
    pushByte(8'hC3);

    // R4 and R5: read drops the flag, redelivery exactly DLY edges later
    readByte();
    chk("R4 dataReady after read", 32'(dataReady), 0);
    chk("R4 rxIrq after read", 32'(rxIrq), 0);
    waitCyc(DLY - 1);
    chk("R5 not yet redelivered", 32'(dataReady), 0);
    waitCyc(1);
    chk("R5 redelivered", 32'(dataReady), 1);

    // R6: second read mid-delay restarts the countdown
    pushByte(8'hD4);
    readByte();
    waitCyc(5);
    readByte();
    waitCyc(DLY - 1);
    chk("R6 countdown restarted", 32'(dataReady), 0);
    waitCyc(1);
    chk("R6 redelivered after restart", 32'(dataReady), 1);
    readByte();
    waitCyc(DLY + 2);
    chk("R5 empty stays low", 32'(dataReady), 0);

    // R7: empty read returns the last byte, then next push follows
    readByte();
    pushByte(8'h3C);
    readByte();

    // R8: push during a pending delay raises the flag at once
    pushByte(8'h11);
    pushByte(8'h22);
    readByte();
    waitCyc(2);
    pushByte(8'h33);
    chk("R8 push during delay", 32'(dataReady), 1);
    readByte();
    readByte();

    // R9: fill, overflow, drain across the pointer wrap
    for (int i = 0; i < DEPTH; i++) pushByte(8'(i * 7 + 1));
    chk("R9 no overflow when exactly full", 32'(overflow), 0);
    pushByte(8'hEE);
    chk("R9 overflow on full push", 32'(overflow), 1);
    for (int i = 0; i < DEPTH; i++) readByte();
    chk("R9 overflow sticky", 32'(overflow), 1);
    pushByte(8'h71);
    pushByte(8'h72);
    readByte();
    readByte();

    // R10: clear during a pending delay
    pushByte(8'h81);
    pushByte(8'h82);
    pushByte(8'h83);
    readByte();
    @(negedge clk);
    clearBuf = 1'b1;
    modelQ.delete();
    @(negedge clk);
    clearBuf = 1'b0;
    chk("R10 dataReady cleared", 32'(dataReady), 0);
    chk("R10 rxIrq cleared", 32'(rxIrq), 0);
    chk("R10 overflow cleared", 32'(overflow), 0);
    waitCyc(DLY + 2);
    chk("R10 delay cancelled", 32'(dataReady), 0);
    readByte();
    pushByte(8'h5A);
    chk("R10 push after clear", 32'(dataReady), 1);
    readByte();

    waitCyc(3);
    chk("R3 scoreboard drained", 32'(expQ.size()), 0);
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end
endmodule